// File: doc/BRIEF.md
# Length-Prefixed Transmit Frame FIFO

This block gathers one outgoing Ethernet frame from a host that pushes 32-bit words into a byte buffer of `BUF_BYTES` bytes (2048 by default). The first word pushed into an empty buffer holds the payload length in its low half. Each later word carries header, payload and, when the host appends its own CRC, the check bytes. After every data write the block works out two things. It checks whether the buffer now holds the whole frame. It also checks whether a programmable fill threshold has been met. When both hold, the frame starts to stream out one byte per handshake.

The output stream leaves out the two length bytes. It carries the 14 header bytes plus the payload. When padding is on, short frames are extended with zeros to the 60-byte minimum. The host can also force a transmission at any time while the block is idle. Once the last byte has gone, the buffer empties and a one-cycle transmit-empty pulse is raised. If the length word is too long, it is refused with a one-cycle transmit-error pulse. Acknowledging that error empties the buffer.

Top module: `tx_frame_fifo`

## Requirements
- R1: When the buffer is empty, bits 15:0 of the next accepted word are the payload length; a length above `BUF_BYTES-16` rejects the word, which is not stored, and `tx_err_o` is high for the one cycle after that write.
- R2: An accepted word that is not rejected is stored as four bytes in little-endian order (bits 7:0 at the lowest byte offset) at the current fill count, which then grows by 4, but only if at least four bytes are free; otherwise the word is dropped and the count is unchanged.
- R3: The frame is complete when the fill count is at least the payload length plus 16, plus 4 more when `crc_auto_i` is low, with the required count capped at `BUF_BYTES`.
- R4: The 6-bit threshold register is loaded from `thr_i` when `thr_we_i` is high and resets to 63; the value 63 disables automatic transmission, and any other value T is met when the fill count is at least 32*T+4.
- R5: Automatic transmission begins only from a data write that is not rejected, and only when both the threshold and completion hold on the count that includes that write; streaming starts on the next cycle.
- R6: The stream carries buffer byte offsets 2 upward, payload length plus 14 bytes in all, capped at `BUF_BYTES-2`; a byte at an offset at or past the fill count, or at or past payload length plus 16, is sent as 0; `tx_last_o` marks the final byte; a stalled byte stays on the output unchanged.
- R7: With `pad_en_i` high at the start of a frame, a stream shorter than 60 bytes is lengthened to 60 bytes, the added bytes being zero.
- R8: `tx_req_i` high while idle starts a transmission whatever the threshold and completion; after the final byte is accepted the fill count returns to zero and `tx_empty_o` is high for one cycle.
- R9: `err_ack_i` high while idle and with no forced start in that cycle empties the buffer, so the next word is taken as a new length word.
- R10: `wr_ready_o` is high only while no frame is streaming and neither `tx_req_i` nor `err_ack_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Host data word valid |
| wr_data_i | input | 32 | Host data word |
| wr_ready_o | output | 1 | Data word can be taken this cycle |
| thr_we_i | input | 1 | Load the threshold register |
| thr_i | input | 6 | New threshold code |
| crc_auto_i | input | 1 | High when CRC is inserted downstream (no CRC bytes in the buffer) |
| pad_en_i | input | 1 | Pad short frames to 60 bytes |
| tx_req_i | input | 1 | Force a transmission |
| err_ack_i | input | 1 | Acknowledge transmit error and empty the buffer |
| tx_data_o | output | 8 | Frame byte |
| tx_valid_o | output | 1 | Frame byte valid |
| tx_ready_i | input | 1 | Downstream takes the byte |
| tx_last_o | output | 1 | Final byte of the frame |
| tx_err_o | output | 1 | Length word rejected (one-cycle pulse) |
| tx_empty_o | output | 1 | Frame finished, buffer empty (one-cycle pulse) |

## Verification
The bench builds the block with `BUF_BYTES = 128`. At that size the longest legal payload is 112 bytes. This brings several limits within a few dozen writes: the completion cap, where a 112-byte payload without CRC needs 132 bytes but only 128 fit; a full buffer dropping a 33rd word; and the 126-byte stream length. Threshold codes 0 to 3 cover every reachable fill point, so the bench sees a frame that is complete but held back until the fill count catches up with the threshold.

// File: rtl/tx_fifo_pkg.sv
package tx_fifo_pkg;
  localparam int unsigned LEN_W     = 16;
  localparam int unsigned HDR_BYTES = 14;
  localparam int unsigned PFX_BYTES = 2;
  localparam int unsigned MIN_FRAME = 60;
  localparam logic [5:0]  THR_OFF   = 6'h3F;
endpackage

// File: rtl/tx_frame_calc.sv
module tx_frame_calc
  import tx_fifo_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 2048,
  parameter int unsigned CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [5:0]       thr_i,
  input  logic             crc_auto_i,
  input  logic             pad_en_i,
  output logic             complete_o,
  output logic             thr_hit_o,
  output logic [CNT_W-1:0] send_len_o
);
  localparam logic [17:0] BUF_W  = 18'(BUF_BYTES);
  localparam logic [17:0] SEND_MAX = 18'(BUF_BYTES - PFX_BYTES);

  logic [17:0] cnt_w, need_raw, need, thr_lvl, send_raw, send_pad;

  always_comb begin
    cnt_w    = 18'(cnt_i);
    need_raw = 18'(len_i) + 18'(HDR_BYTES + PFX_BYTES) + (crc_auto_i ? 18'd0 : 18'd4);
    need     = (need_raw > BUF_W) ? BUF_W : need_raw;
    complete_o = cnt_w >= need;

    thr_lvl   = (18'(thr_i) << 5) + 18'd4;
    thr_hit_o = (thr_i != THR_OFF) && (cnt_w >= thr_lvl);

    send_raw = 18'(len_i) + 18'(HDR_BYTES);
    send_pad = (pad_en_i && send_raw < 18'(MIN_FRAME)) ? 18'(MIN_FRAME) : send_raw;
    send_len_o = CNT_W'((send_pad > SEND_MAX) ? SEND_MAX : send_pad);
  end
endmodule

// File: rtl/tx_buf_mem.sv
module tx_buf_mem #(
  parameter int unsigned BUF_BYTES = 2048,
  parameter int unsigned AW        = $clog2(BUF_BYTES),
  parameter int unsigned WORDS     = BUF_BYTES / 4
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-3:0] waddr_i,
  input  logic [31:0]   wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [31:0] mem_q [WORDS];
  logic [31:0] rword;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // little-endian byte select
  always_comb begin
    rword   = mem_q[raddr_i[AW-1:2]];
    rdata_o = rword[8*raddr_i[1:0] +: 8];
  end
endmodule

// File: rtl/tx_byte_streamer.sv
module tx_byte_streamer #(
  parameter int unsigned BUF_BYTES = 2048,
  parameter int unsigned CNT_W     = $clog2(BUF_BYTES + 1),
  parameter int unsigned AW        = $clog2(BUF_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] end_i,
  input  logic [CNT_W-1:0] fill_i,
  input  logic [16:0]      hdr_end_i,
  input  logic [7:0]       mem_byte_i,
  output logic [AW-1:0]    raddr_o,
  output logic [7:0]       tx_data_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic             tx_last_o,
  output logic             done_o
);
  logic             busy_q;
  logic [CNT_W-1:0] idx_q, end_q, fill_q;
  logic [16:0]      hdr_q;
  logic             live;

  assign raddr_o    = idx_q[AW-1:0];
  assign tx_valid_o = busy_q;
  assign tx_last_o  = busy_q && (idx_q == end_q - CNT_W'(1));
  assign live       = (idx_q < fill_q) && (17'(idx_q) < hdr_q);
  assign tx_data_o  = live ? mem_byte_i : 8'h00;
  assign done_o     = tx_last_o && tx_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      end_q  <= '0;
      fill_q <= '0;
      hdr_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= CNT_W'(2);
      end_q  <= end_i;
      fill_q <= fill_i;
      hdr_q  <= hdr_end_i;
    end else if (busy_q && tx_ready_i) begin
      if (tx_last_o) busy_q <= 1'b0;
      else           idx_q  <= idx_q + CNT_W'(1);
    end
  end

  // R6
  hold_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tx_ready_i) |=> (busy_q && $stable(tx_data_o) && $stable(tx_last_o)));
  // R6
  idx_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (idx_q < end_q && end_q <= CNT_W'(BUF_BYTES)));
endmodule

// File: rtl/tx_frame_fifo.sv
module tx_frame_fifo
  import tx_fifo_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 2048
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_valid_i,
  input  logic [31:0] wr_data_i,
  output logic        wr_ready_o,
  input  logic        thr_we_i,
  input  logic [5:0]  thr_i,
  input  logic        crc_auto_i,
  input  logic        pad_en_i,
  input  logic        tx_req_i,
  input  logic        err_ack_i,
  output logic [7:0]  tx_data_o,
  output logic        tx_valid_o,
  input  logic        tx_ready_i,
  output logic        tx_last_o,
  output logic        tx_err_o,
  output logic        tx_empty_o
);
  localparam int unsigned CNT_W   = $clog2(BUF_BYTES + 1);
  localparam int unsigned AW      = $clog2(BUF_BYTES);
  localparam int unsigned MAX_LEN = BUF_BYTES - HDR_BYTES - PFX_BYTES;

  logic [CNT_W-1:0] count_q, cnt_nxt, send_len, end_idx;
  logic [LEN_W-1:0] len_q, len_word, len_eff;
  logic [5:0]       thr_q;
  logic             tx_err_q, tx_empty_q;
  logic             wr_fire, first_wr, reject, has_room, store;
  logic             complete, thr_hit, auto_go, force_go, start, clr, done;
  logic [AW-1:0]    raddr;
  logic [7:0]       mem_byte;

  assign wr_ready_o = !tx_valid_o && !tx_req_i && !err_ack_i;
  assign wr_fire    = wr_valid_i && wr_ready_o;
  assign len_word   = wr_data_i[LEN_W-1:0];
  assign first_wr   = wr_fire && (count_q == '0);
  assign reject     = first_wr && (len_word > LEN_W'(MAX_LEN));
  assign has_room   = count_q <= CNT_W'(BUF_BYTES - 4);
  assign store      = wr_fire && !reject && has_room;
  assign cnt_nxt    = store ? count_q + CNT_W'(4) : count_q;
  assign len_eff    = first_wr ? len_word : len_q;

  tx_frame_calc #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_calc (
    .cnt_i      (cnt_nxt),
    .len_i      (len_eff),
    .thr_i      (thr_q),
    .crc_auto_i (crc_auto_i),
    .pad_en_i   (pad_en_i),
    .complete_o (complete),
    .thr_hit_o  (thr_hit),
    .send_len_o (send_len)
  );

  // completion judged on the count that already includes this write
  assign auto_go  = wr_fire && !reject && complete && thr_hit;
  assign force_go = tx_req_i && !tx_valid_o;
  assign start    = auto_go || force_go;
  assign clr      = err_ack_i && !tx_valid_o && !start;
  assign end_idx  = send_len + CNT_W'(PFX_BYTES);

  tx_buf_mem #(.BUF_BYTES(BUF_BYTES), .AW(AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (store),
    .waddr_i (count_q[AW-1:2]),
    .wdata_i (wr_data_i),
    .raddr_i (raddr),
    .rdata_o (mem_byte)
  );

  tx_byte_streamer #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W), .AW(AW)) u_stream (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .end_i      (end_idx),
    .fill_i     (cnt_nxt),
    .hdr_end_i  (17'(len_eff) + 17'(HDR_BYTES + PFX_BYTES)),
    .mem_byte_i (mem_byte),
    .raddr_o    (raddr),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .tx_last_o  (tx_last_o),
    .done_o     (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q    <= '0;
      len_q      <= '0;
      thr_q      <= THR_OFF;
      tx_err_q   <= 1'b0;
      tx_empty_q <= 1'b0;
    end else begin
      tx_err_q   <= reject;
      tx_empty_q <= done;
      if (thr_we_i) thr_q <= thr_i;
      if (first_wr && !reject) len_q <= len_word;
      if (done || clr) count_q <= '0;
      else             count_q <= cnt_nxt;
    end
  end

  assign tx_err_o   = tx_err_q;
  assign tx_empty_o = tx_empty_q;

  // R2
  no_overfill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(BUF_BYTES));
  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q != $past(count_q)) |-> (count_q == '0 || count_q == $past(count_q) + CNT_W'(4)));
  // R8
  empty_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> (count_q == '0 && !tx_valid_o));
  // R1
  reject_keeps_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_err_o |-> (count_q == '0 && !tx_valid_o));
  // R10
  frozen_while_streaming_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_last_o) |=> $stable(count_q));
endmodule

// File: tb/tb_tx_frame_fifo.sv
module tb_tx_frame_fifo;
  localparam int BUF = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready;
  logic        thr_we = 1'b0;
  logic [5:0]  thr = '0;
  logic        crc_auto = 1'b1;
  logic        pad_en = 1'b0;
  logic        tx_req = 1'b0;
  logic        err_ack = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic        tx_last;
  logic        tx_err;
  logic        tx_empty;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  tx_frame_fifo #(.BUF_BYTES(BUF)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .thr_we_i(thr_we), .thr_i(thr), .crc_auto_i(crc_auto), .pad_en_i(pad_en),
    .tx_req_i(tx_req), .err_ack_i(err_ack),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .tx_last_o(tx_last), .tx_err_o(tx_err), .tx_empty_o(tx_empty)
  );

  typedef struct packed {
    int len; int nw; int th;
    bit crc; bit pad; bit frc; bit stl;
    int elen;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{20, 9, 0, 1'b1, 1'b0, 1'b0, 1'b0, 34},   // R5 R6 plain auto
    '{20, 10, 0, 1'b0, 1'b1, 1'b0, 1'b1, 60},  // R3 R7 CRC words, padded
    '{46, 16, 1, 1'b1, 1'b1, 1'b0, 1'b0, 60},  // R7 exactly 60, no pad added
    '{8, 6, 3, 1'b1, 1'b0, 1'b1, 1'b0, 22},    // R4 threshold unmet, forced
    '{8, 6, 63, 1'b1, 1'b1, 1'b1, 1'b1, 60},   // R4 disabled, forced, padded
    '{112, 32, 3, 1'b0, 1'b0, 1'b0, 1'b0, 126},// R3 completion cap
    '{4, 17, 2, 1'b1, 1'b0, 1'b0, 1'b0, 18},   // R5 complete but held by threshold
    '{112, 33, 63, 1'b0, 1'b0, 1'b1, 1'b1, 126},// R2 full buffer drops word
    '{40, 4, 63, 1'b1, 1'b0, 1'b1, 1'b0, 54}   // R6 unwritten bytes read as 0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_val(input int w, input int len);
    if (w == 0) return {16'hC3B2, 16'(len)};
    return {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)} ^ 32'h5A5A5A5A;
  endfunction

  function automatic logic [7:0] exp_byte(input int b, input int cnt, input int len);
    logic [31:0] w;
    if (b >= cnt || b >= len + 16) return 8'h00;
    w = word_val(b / 4, len);
    return w[8*(b%4) +: 8];
  endfunction

  task automatic wr_word(input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(posedge clk);
    #1 wr_valid = 1'b0;
  endtask

  task automatic set_thr(input int v);
    @(negedge clk);
    thr_we = 1'b1;
    thr = 6'(v);
    @(posedge clk);
    #1 thr_we = 1'b0;
  endtask

  task automatic force_tx();
    @(negedge clk);
    tx_req = 1'b1;
    @(posedge clk);
    #1 tx_req = 1'b0;
  endtask

  // writes a frame; checks no early start and whether the last write starts one
  task automatic wr_frame(input int len, input int nw, input bit auto_exp);
    for (int k = 0; k < nw; k++) begin
      wr_word(word_val(k, len));
      @(negedge clk);
      if (k < nw - 1) chk("R5", tx_valid, 1'b0, "early start");
      else            chk("R5", tx_valid, auto_exp, "start after last write");
    end
  endtask

  task automatic collect(input int elen, input int len, input int cnt, input bit stl);
    int got = 0;
    for (int g = 0; g < 4000 && got < elen; g++) begin
      @(negedge clk);
      tx_ready = stl ? (g % 2 == 1) : 1'b1;
      if (tx_valid && tx_ready) begin
        chk("R6", tx_data, exp_byte(got + 2, cnt, len), "byte");
        chk("R6", tx_last, (got == elen - 1), "last flag");
        chk("R10", wr_ready, 1'b0, "ready while streaming");
        got++;
      end
      @(posedge clk);
    end
    #1 tx_ready = 1'b0;
    chk("R6", got, elen, "frame length");
    @(negedge clk);
    chk("R8", tx_empty, 1'b1, "empty pulse");
    chk("R8", tx_valid, 1'b0, "idle after frame");
    @(negedge clk);
    chk("R8", tx_empty, 1'b0, "empty pulse width");
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R10", wr_ready, 1'b1, "reset ready");
    chk("R6", tx_valid, 1'b0, "reset valid");
    chk("R1", tx_err, 1'b0, "reset err");
    chk("R8", tx_empty, 1'b0, "reset empty");

    // R4: reset threshold of 63 blocks automatic start
    crc_auto = 1'b1; pad_en = 1'b0;
    wr_frame(8, 6, 1'b0);
    force_tx();
    collect(22, 8, 24, 1'b0);

    // table walk
    for (int v = 0; v < 9; v++) begin
      int cnt;
      cnt = (VECS[v].nw * 4 > BUF) ? BUF : VECS[v].nw * 4;
      crc_auto = VECS[v].crc;
      pad_en   = VECS[v].pad;
      set_thr(VECS[v].th);
      wr_frame(VECS[v].len, VECS[v].nw, !VECS[v].frc);
      if (VECS[v].frc) force_tx();
      collect(VECS[v].elen, VECS[v].len, cnt, VECS[v].stl);
    end

    // R1: oversize length word rejected, not stored
    crc_auto = 1'b1; pad_en = 1'b0;
    set_thr(0);
    wr_word(32'h0000_0071);
    @(negedge clk);
    chk("R1", tx_err, 1'b1, "error pulse");
    chk("R1", tx_valid, 1'b0, "no start on reject");
    @(negedge clk);
    chk("R1", tx_err, 1'b0, "error pulse width");
    wr_frame(4, 5, 1'b1);
    collect(18, 4, 20, 1'b0);

    // R9 R10: acknowledge empties a partly filled buffer
    wr_frame(40, 3, 1'b0);
    @(negedge clk);
    err_ack = 1'b1;
    #1 chk("R10", wr_ready, 1'b0, "ready during ack");
    @(posedge clk);
    #1 err_ack = 1'b0;
    @(negedge clk);
    chk("R10", wr_ready, 1'b1, "ready after ack");
    wr_frame(4, 5, 1'b1);
    collect(18, 4, 20, 1'b1);

    // R10: request blocks writes in its cycle
    @(negedge clk);
    tx_req = 1'b1;
    #1 chk("R10", wr_ready, 1'b0, "ready during request");
    @(posedge clk);
    #1 tx_req = 1'b0;
    collect(18, 4, 0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule